// File: doc/BRIEF.md
# Timecode Frame Transmitter

This block assembles a fixed 20-byte timecode frame and hands it out one byte per accepted symbol, each byte paired with a control-symbol flag. A downstream 8b10b encoder and serializer consume the stream. Between frames the stream carries the comma idle byte 0xBC with the flag raised.

A one-cycle start request is honoured only while the channel is idle and the spill gate is low. On that cycle the block captures the seconds, nanoseconds, flag bits and spill identifier, so the time in the frame is the time at the frame's first symbol. The frame holds a type byte, the time fields, the spill identifier, two zero bytes and a CRC32 that is computed byte by byte as the body goes out.

The output is a valid/ready stream, and `tx_valid` is always high. A symbol is consumed on each cycle where `tx_ready` is high, so `tx_ready` sets the byte rate. While `tx_ready` is low, the symbol and its flag stay unchanged and the frame does not advance.

Top module: `tcf_tx`

## Requirements
- R1: When no frame is in progress, `tx_data` is 0xBC, `tx_k` is 1 and `tx_valid` is 1.
- R2: A start pulse accepted while idle with spill low raises `busy` at the next edge. The first symbol after that is the type byte, which defaults to 0x01, with `tx_k` = 0.
- R3: A frame is exactly 20 consumed non-control symbols. After the 20th, `busy` falls and the stream returns to idle.
- R4: Bytes 1 to 5 carry seconds bits 39:0, most significant byte first.
- R5: Bytes 6 to 9 carry nanoseconds bits 29:0, most significant first. Byte 9 holds nanoseconds 5:0 in bits 7:2 and flags 1:0 in bits 1:0.
- R6: Bytes 10 to 13 carry the spill identifier, most significant byte first. Bytes 14 and 15 are 0x00.
- R7: Bytes 16 to 19 are the standard Ethernet CRC32 of bytes 0 to 15, most significant byte first. The CRC uses the reflected polynomial 0xEDB88320, an initial value of all ones and a final inversion.
- R8: While `tx_ready` is low, `tx_data` and `tx_k` hold their values and the frame position does not advance.
- R9: A start pulse while spill is high is ignored: `busy` stays 0 and the stream stays idle.
- R10: A start pulse while a frame is in progress is ignored. Field inputs that change after the accepted start do not alter the frame.
- R11: After reset, `busy` is 0 and the stream is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| spill | input | 1 | Spill gate; frames are allowed only while it is low |
| start | input | 1 | One-cycle frame request |
| tai_sec | input | 40 | Seconds field, captured on an accepted start |
| tai_ns | input | 30 | Nanoseconds field, captured on an accepted start |
| tai_flags | input | 2 | Flag bits, captured on an accepted start |
| spill_id | input | 32 | Spill identifier, captured on an accepted start |
| tx_ready | input | 1 | Downstream accepts the current symbol |
| busy | output | 1 | Frame in progress |
| tx_data | output | 8 | Symbol byte |
| tx_k | output | 1 | Control-symbol flag |
| tx_valid | output | 1 | Symbol valid, always 1 |

## Verification
The bench builds the block with its default parameters: frame type 1 and idle byte 0xBC. This exposes the complete type-1 layout, including the nanoseconds and flags packing and the CRC trailer. The frames use all-ones, all-zeros and mixed field values. A pseudo-random `tx_ready` pattern exercises back-pressure at every byte position, including the CRC bytes.

// File: rtl/tcf_pkg.sv
package tcf_pkg;
  localparam int FRAME_BYTES = 20;
  localparam int BODY_BYTES  = 16;
  localparam int SEC_W       = 40;
  localparam int NS_W        = 30;
  localparam int FLAG_W      = 2;
  localparam int SID_W       = 32;
  localparam int IDX_W       = $clog2(FRAME_BYTES);

  typedef struct packed {
    logic [SEC_W-1:0]  sec;
    logic [NS_W-1:0]   ns;
    logic [FLAG_W-1:0] flags;
    logic [SID_W-1:0]  sid;
  } tcf_fields_t;

  // One byte of reflected CRC32, least significant input bit first.
  function automatic logic [31:0] crc32_step(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    r = c;
    for (int b = 0; b < 8; b++) begin
      r = (r >> 1) ^ (((r[0] ^ d[b]) != 1'b0) ? 32'hEDB88320 : 32'h0);
    end
    return r;
  endfunction
endpackage

// File: rtl/tcf_seq.sv
module tcf_seq
  import tcf_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             spill,
  input  logic             ready,
  output logic             active,
  output logic             load,
  output logic             step,
  output logic [IDX_W-1:0] idx
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(FRAME_BYTES - 1);

  assign load = !active && start && !spill;
  assign step = active && ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      idx    <= '0;
    end else if (load) begin
      active <= 1'b1;
      idx    <= '0;
    end else if (step) begin
      if (idx == LAST) begin
        active <= 1'b0;
        idx    <= '0;
      end else begin
        idx <= idx + 1'b1;
      end
    end
  end

  // R2: every frame begins at position zero
  p_first_pos_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active) |-> idx == '0);
  // R9: spill high keeps an idle channel idle
  p_spill_block_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && spill) |=> !active);
  // R8: position frozen without ready
  p_pos_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !ready) |=> (active && $stable(idx)));
endmodule

// File: rtl/tcf_crc.sv
module tcf_crc
  import tcf_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clear,
  input  logic        en,
  input  logic [7:0]  din,
  output logic [31:0] crc
);
  logic [31:0] acc;

  always_ff @(posedge clk) begin
    if (!rst_n || clear) acc <= '1;
    else if (en)         acc <= crc32_step(acc, din);
  end

  assign crc = ~acc;
endmodule

// File: rtl/tcf_pack.sv
module tcf_pack
  import tcf_pkg::*;
#(
  parameter logic [7:0] FRAME_TYPE = 8'h01
) (
  input  tcf_fields_t      fields,
  input  logic [IDX_W-1:0] idx,
  input  logic [31:0]      crc,
  output logic [7:0]       byte_out
);
  localparam int BODY_W = BODY_BYTES * 8;
  localparam int RSV_W  = BODY_W - 8 - SEC_W - NS_W - FLAG_W - SID_W;

  logic [BODY_W-1:0] body;
  assign body = {FRAME_TYPE, fields.sec, fields.ns, fields.flags, fields.sid, {RSV_W{1'b0}}};

  always_comb begin
    int pos;
    pos = int'(idx);
    if (pos < BODY_BYTES) byte_out = body[8*(BODY_BYTES-1-pos) +: 8];
    else                  byte_out = crc[8*(FRAME_BYTES-1-pos) +: 8];
  end
endmodule

// File: rtl/tcf_tx.sv
module tcf_tx
  import tcf_pkg::*;
#(
  parameter logic [7:0] FRAME_TYPE = 8'h01,
  parameter logic [7:0] IDLE_SYM   = 8'hBC
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        spill,
  input  logic        start,
  input  logic [39:0] tai_sec,
  input  logic [29:0] tai_ns,
  input  logic [1:0]  tai_flags,
  input  logic [31:0] spill_id,
  input  logic        tx_ready,
  output logic        busy,
  output logic [7:0]  tx_data,
  output logic        tx_k,
  output logic        tx_valid
);
  logic             active, load, step;
  logic [IDX_W-1:0] idx;
  logic [31:0]      crc;
  logic [7:0]       frame_byte;
  tcf_fields_t      held;

  tcf_seq u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .spill(spill), .ready(tx_ready),
    .active(active), .load(load), .step(step), .idx(idx)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)    held <= '0;
    else if (load) held <= '{sec: tai_sec, ns: tai_ns, flags: tai_flags, sid: spill_id};
  end

  tcf_pack #(.FRAME_TYPE(FRAME_TYPE)) u_pack (
    .fields(held), .idx(idx), .crc(crc), .byte_out(frame_byte)
  );

  tcf_crc u_crc (
    .clk(clk), .rst_n(rst_n), .clear(load),
    .en(step && (int'(idx) < BODY_BYTES)), .din(frame_byte), .crc(crc)
  );

  assign busy     = active;
  assign tx_valid = 1'b1;
  assign tx_k     = !active;
  assign tx_data  = active ? frame_byte : IDLE_SYM;

  // R8: symbol and flag held under back-pressure
  p_sym_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready && busy) |=> ($stable(tx_data) && $stable(tx_k)));
  // R2: accepted start raises busy at the next edge
  p_start_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start && !spill) |=> busy);
  // R10: field latch frozen during a frame
  p_fields_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(held));
  // R1: the idle stream never drops valid
  p_valid_r1: assert property (@(posedge clk) disable iff (!rst_n) tx_valid);
endmodule

// File: tb/sim_tcf_tx.sv
module sim_tcf_tx;
  logic        clk = 1'b0, rst_n = 1'b0, spill = 1'b0, start = 1'b0, tx_ready = 1'b1;
  logic [39:0] tai_sec = '0;
  logic [29:0] tai_ns = '0;
  logic [1:0]  tai_flags = '0;
  logic [31:0] spill_id = '0;
  logic        busy, tx_k, tx_valid;
  logic [7:0]  tx_data;

  int errors = 0, checks = 0;
  logic [7:0] expq[$];
  logic       rdy_rand = 1'b0;
  int         infr = 0;

  always #10 clk = ~clk;

  tcf_tx u0 (.clk(clk), .rst_n(rst_n), .spill(spill), .start(start), .tai_sec(tai_sec),
    .tai_ns(tai_ns), .tai_flags(tai_flags), .spill_id(spill_id), .tx_ready(tx_ready),
    .busy(busy), .tx_data(tx_data), .tx_k(tx_k), .tx_valid(tx_valid));

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] ref_crc(input logic [7:0] m[16]);
    logic [31:0] c = 32'hFFFFFFFF;
    foreach (m[i]) begin
      c ^= {24'h0, m[i]};
      for (int k = 0; k < 8; k++) c = c[0] ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
    end
    return ~c;
  endfunction

  // Driver: queue the expected frame, then pulse start
  task automatic send(input logic [39:0] s, input logic [29:0] n, input logic [1:0] f, input logic [31:0] id);
    logic [7:0] m[16];
    logic [31:0] c;
    logic [31:0] w;
    m[0] = 8'h01;
    for (int i = 0; i < 5; i++) m[1+i] = s[39-8*i -: 8];
    w = {n, f};
    for (int i = 0; i < 4; i++) m[6+i] = w[31-8*i -: 8];
    for (int i = 0; i < 4; i++) m[10+i] = id[31-8*i -: 8];
    m[14] = 8'h00; m[15] = 8'h00;
    c = ref_crc(m);
    foreach (m[i]) expq.push_back(m[i]);
    for (int i = 0; i < 4; i++) expq.push_back(c[31-8*i -: 8]);
    @(posedge clk); #2;
    tai_sec = s; tai_ns = n; tai_flags = f; spill_id = id; start = 1'b1;
    @(posedge clk); #2;
    start = 1'b0;
    chk(busy === 1'b1, "R2 busy", {63'h0, busy}, 64'h1);
  endtask

  task automatic wait_done();
    int guard = 0;
    while ((busy || expq.size() != 0) && guard < 2000) begin
      @(posedge clk); guard++;
    end
    #2;
    chk(busy === 1'b0 && expq.size() == 0, "R3 frame end", {63'h0, busy}, 64'h0);
  endtask

  // Ready pattern
  always @(posedge clk) begin
    #2;
    if (rdy_rand) tx_ready = ($urandom % 3) != 0;
  end

  // Monitor: compare consumed symbols; check hold under back-pressure
  logic [7:0] pd; logic pk; logic pheld = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (pheld) chk(tx_data === pd && tx_k === pk, "R8 hold", {55'h0, tx_k, tx_data}, {55'h0, pk, pd});
      pheld = !tx_ready && !tx_k;
      pd = tx_data; pk = tx_k;
      if (tx_ready && tx_valid) begin
        if (!tx_k) begin
          if (expq.size() == 0) chk(1'b0, "R10 unexpected byte", {56'h0, tx_data}, 64'h0);
          else begin
            logic [7:0] e;
            e = expq.pop_front();
            chk(tx_data === e, $sformatf("R4-R7 byte %0d (R4 R5 R6 R7 R2)", infr), {56'h0, tx_data}, {56'h0, e});
          end
          infr++;
        end else begin
          if (infr != 0) chk(infr == 20 && tx_data === 8'hBC, "R3 length", infr, 20);
          infr = 0;
        end
      end
    end
  end

  initial begin
    fork
      begin
        repeat (4) @(posedge clk); #2;
        rst_n = 1'b1;
        #1;
        chk(busy === 1'b0, "R11 busy", {63'h0, busy}, 64'h0);
        chk(tx_k === 1'b1 && tx_data === 8'hBC && tx_valid === 1'b1, "R1 idle", {55'h0, tx_k, tx_data}, {55'h0, 1'b1, 8'hBC});
        send(40'h12_3456_789A, 30'h2ABC_DEF1, 2'b10, 32'hDEAD_BEEF); wait_done();
        send('1, '1, 2'b11, '1); wait_done();
        send('0, '0, 2'b00, '0); wait_done();
        // R9: spill high blocks start
        @(posedge clk); #2; spill = 1'b1; start = 1'b1;
        @(posedge clk); #2; start = 1'b0;
        repeat (5) @(posedge clk); #2;
        chk(busy === 1'b0 && tx_k === 1'b1 && tx_data === 8'hBC, "R9 spill ignore", {63'h0, busy}, 64'h0);
        spill = 1'b0;
        // R8 with random ready, R10 start mid-frame and field changes
        rdy_rand = 1'b1;
        send(40'h00_0102_0304, 30'h0000_0155, 2'b01, 32'h0A0B_0C0D);
        repeat (6) @(posedge clk); #2;
        tai_sec = 40'hFF_FFFF_0000; spill_id = 32'h5555_AAAA; start = 1'b1;
        @(posedge clk); #2; start = 1'b0;
        wait_done();
        send(40'h80_0000_0001, 30'h2000_0000, 2'b10, 32'h8000_0001); wait_done();
        rdy_rand = 1'b0; tx_ready = 1'b1;
        repeat (3) @(posedge clk); #2;
        chk(busy === 1'b0 && tx_k === 1'b1, "R10 no extra frame", {63'h0, busy}, 64'h0);
      end
      begin
        repeat (100000) @(posedge clk);
        chk(1'b0, "watchdog", 0, 1);
      end
    join_any
    disable fork;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule